// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block moves a processor core between three operating states: running, halted and dozing. Software enters a low-power state by writing control bits into a configuration word. The controller then switches off the core clock enables. In doze it keeps the write-buffer clock running until pending stores have drained, and it goes on granting external bus-release requests. In halt both of those are frozen.

On wake-up the controller returns the core to the running state. It issues a one-cycle wake pulse that tells the core what to do next:
- take an exception, recording whether a reset request, NMI or interrupt caused it; or
- resume silently at the next instruction.

The controller also holds a reduced-frequency divider select. Every configuration write loads it, whatever state the controller is in.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the outputs are as follows: `mode` = 0 (run), `core_clk_en` = 1, `wb_clk_en` = 1, `bus_ack` = 0, `wake_valid` = 0 and `rf_div` = 0.
- R2: In run, a configuration write with bit 8 set gives `mode` = 1 (halt) on the next cycle, with `core_clk_en` = 0 and `wb_clk_en` = 0. Bit 8 wins when bit 9 is also set.
- R3: In run, a configuration write with bit 9 set and bit 8 clear gives `mode` = 2 (doze) on the next cycle, with `core_clk_en` = 0. While dozing, `wb_clk_en` equals the inverse of `wb_empty` sampled at the previous clock edge.
- R4: `bus_ack` equals `bus_req` from the previous edge whenever the new mode is run or doze. It is 0 whenever the new mode is halt.
- R5: The halt state is left only on `core_rst_req`, `nmi` or an enabled interrupt. An interrupt that is disabled by the mask leaves the controller in halt.
- R6: The doze state is left on `core_rst_req`, `nmi` or any asserted interrupt line, whether enabled or disabled.
- R7: On leaving halt or doze, `mode` returns to 0 and `wake_valid` pulses for exactly one cycle in that same cycle. `wake_exc` is 1 if the wake came from a reset request, NMI or an enabled interrupt. It is 0 if the wake came only from disabled interrupts, in which case the core resumes.
- R8: `wake_cause` reports the highest-priority source present at the wake edge: 1 for a reset request, 2 for NMI, 3 for an interrupt. A reset request outranks NMI, and NMI outranks an interrupt.
- R9: Every configuration write, in any mode, loads bits [1:0] into `rf_div` on the next cycle. A write made while halted or dozing does not change `mode`.
- R10: `int_mask` bit i (for i from 0 to 7) enables `ext_int[i]`, and bit 8 enables all of `periph_irq`. A value of 1 means enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data: bit 8 halt, bit 9 doze, bits [1:0] divider |
| periph_irq | input | 4 | On-chip peripheral interrupt requests |
| ext_int | input | 8 | External interrupt lines |
| nmi | input | 1 | Non-maskable interrupt |
| core_rst_req | input | 1 | Reset request acting as a wake source |
| int_mask | input | 9 | Interrupt enables, with 1 meaning enabled |
| wb_empty | input | 1 | Write buffer is empty |
| bus_req | input | 1 | External bus-release request |
| mode | output | 2 | Current state: 0 run, 1 halt, 2 doze |
| core_clk_en | output | 1 | Core pipeline clock enable |
| wb_clk_en | output | 1 | Write-buffer clock enable |
| bus_ack | output | 1 | Bus-release grant |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_exc | output | 1 | 1 = take the exception, 0 = resume |
| wake_cause | output | 2 | Wake source: 1 reset, 2 NMI, 3 interrupt |
| rf_div | output | 2 | Reduced-frequency divider select |

## Verification
Every result of this block is registered, so each one is due exactly one clock edge after the inputs that cause it. This holds for the mode change, the clock enables, the bus grant, the wake pulse with its action and cause, and the divider select. The bench drives its inputs just after a falling edge and samples the outputs 1 ns after the next rising edge. At that point it advances a reference model by exactly one step, using the inputs it had applied, and compares every output. No check ever looks more than one edge ahead.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int NEXT     = 8,
  parameter int NPERIPH  = 4,
  parameter int CFG_W    = 16,
  parameter int HALT_BIT = 8,
  parameter int DOZE_BIT = 9,
  parameter int RF_LSB   = 0,
  parameter int RF_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic [NPERIPH-1:0] periph_irq,
  input  logic [NEXT-1:0]    ext_int,
  input  logic               nmi,
  input  logic               core_rst_req,
  input  logic [NEXT:0]      int_mask,
  input  logic               wb_empty,
  input  logic               bus_req,
  output logic [1:0]         mode,
  output logic               core_clk_en,
  output logic               wb_clk_en,
  output logic               bus_ack,
  output logic               wake_valid,
  output logic               wake_exc,
  output logic [1:0]         wake_cause,
  output logic [RF_W-1:0]    rf_div
);

  localparam logic [1:0] M_RUN  = 2'd0;
  localparam logic [1:0] M_HALT = 2'd1;
  localparam logic [1:0] M_DOZE = 2'd2;
  localparam logic [1:0] C_RST  = 2'd1;
  localparam logic [1:0] C_NMI  = 2'd2;
  localparam logic [1:0] C_INT  = 2'd3;

  logic       int_any, int_open, wake_ok, leave, go_halt, go_doze, past_ok;
  logic [1:0] mode_nx, cause_nx;

  assign int_any  = (|ext_int) | (|periph_irq);
  assign int_open = (|(ext_int & int_mask[NEXT-1:0])) | ((|periph_irq) & int_mask[NEXT]);
  assign wake_ok  = core_rst_req | nmi | ((mode == M_HALT) ? int_open : int_any);
  assign leave    = (mode != M_RUN) & wake_ok;
  assign go_halt  = (mode == M_RUN) & cfg_we & cfg_wdata[HALT_BIT];
  assign go_doze  = (mode == M_RUN) & cfg_we & ~cfg_wdata[HALT_BIT] & cfg_wdata[DOZE_BIT];
  assign mode_nx  = leave ? M_RUN : go_halt ? M_HALT : go_doze ? M_DOZE : mode;
  assign cause_nx = core_rst_req ? C_RST : nmi ? C_NMI : C_INT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= M_RUN;
      core_clk_en <= 1'b1;
      wb_clk_en   <= 1'b1;
      bus_ack     <= 1'b0;
      wake_valid  <= 1'b0;
      wake_exc    <= 1'b0;
      wake_cause  <= 2'd0;
      rf_div      <= '0;
      past_ok     <= 1'b0;
    end else begin
      mode        <= mode_nx;
      core_clk_en <= (mode_nx == M_RUN);
      wb_clk_en   <= (mode_nx == M_RUN) | ((mode_nx == M_DOZE) & ~wb_empty);
      bus_ack     <= bus_req & (mode_nx != M_HALT);
      wake_valid  <= leave;
      past_ok     <= 1'b1;
      if (leave) begin
        wake_exc   <= core_rst_req | nmi | int_open;
        wake_cause <= cause_nx;
      end
      if (cfg_we) rf_div <= cfg_wdata[RF_LSB +: RF_W];
    end
  end

  p_halt_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HALT) |-> (!core_clk_en && !wb_clk_en));

  p_halt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode == M_RUN && cfg_we && cfg_wdata[HALT_BIT])) |-> (mode == M_HALT));

  p_doze_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode == M_DOZE && $past(mode == M_DOZE) && $past(!wb_empty)) |-> wb_clk_en);

  p_halt_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HALT) |-> !bus_ack);

  p_halt_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode == M_HALT && !core_rst_req && !nmi && !int_open)) |-> (mode == M_HALT));

  p_doze_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode == M_DOZE && (int_any || nmi || core_rst_req))) |-> (mode == M_RUN && wake_valid));

  p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |=> !wake_valid);

  p_resume_from_doze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wake_valid && !wake_exc) |-> ($past(mode) == M_DOZE));

  p_rst_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wake_valid && $past(core_rst_req)) |-> (wake_cause == C_RST));

  p_rf_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_we)) |-> (rf_div == $past(cfg_wdata[RF_LSB +: RF_W])));

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  periph_irq = '0;
  logic [7:0]  ext_int = '0;
  logic        nmi = 1'b0, core_rst_req = 1'b0;
  logic [8:0]  int_mask = '0;
  logic        wb_empty = 1'b1, bus_req = 1'b0;
  logic [1:0]  mode, wake_cause, rf_div;
  logic        core_clk_en, wb_clk_en, bus_ack, wake_valid, wake_exc;

  int checks = 0, fails = 0;
  logic [1:0] m_mode = 0, m_cause = 0, m_rf = 0;
  logic       m_core = 1, m_wb = 1, m_ack = 0, m_wv = 0, m_exc = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .periph_irq(periph_irq), .ext_int(ext_int), .nmi(nmi), .core_rst_req(core_rst_req),
    .int_mask(int_mask), .wb_empty(wb_empty), .bus_req(bus_req), .mode(mode),
    .core_clk_en(core_clk_en), .wb_clk_en(wb_clk_en), .bus_ack(bus_ack),
    .wake_valid(wake_valid), .wake_exc(wake_exc), .wake_cause(wake_cause), .rf_div(rf_div));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic f_open();
    return (|(ext_int & int_mask[7:0])) | ((|periph_irq) & int_mask[8]);
  endfunction

  function automatic logic f_any();
    return (|ext_int) | (|periph_irq);
  endfunction

  task automatic model();
    logic [1:0] nx;
    logic lv;
    nx = m_mode;
    lv = 1'b0;
    if (m_mode == 2'd1) lv = core_rst_req | nmi | f_open();
    else if (m_mode == 2'd2) lv = core_rst_req | nmi | f_any();
    if (lv) nx = 2'd0;
    else if (m_mode == 2'd0 && cfg_we && cfg_wdata[8]) nx = 2'd1;
    else if (m_mode == 2'd0 && cfg_we && cfg_wdata[9]) nx = 2'd2;
    if (lv) begin
      m_exc   = core_rst_req | nmi | f_open();
      m_cause = core_rst_req ? 2'd1 : nmi ? 2'd2 : 2'd3;
    end
    m_wv   = lv;
    m_mode = nx;
    m_core = (nx == 2'd0);
    m_wb   = (nx == 2'd0) | ((nx == 2'd2) & ~wb_empty);
    m_ack  = bus_req & (nx != 2'd1);
    if (cfg_we) m_rf = cfg_wdata[1:0];
  endtask

  task automatic cmp();
    chk("R5 mode", mode, m_mode);
    chk("R2 core_clk_en", core_clk_en, m_core);
    chk("R3 wb_clk_en", wb_clk_en, m_wb);
    chk("R4 bus_ack", bus_ack, m_ack);
    chk("R7 wake_valid", wake_valid, m_wv);
    if (m_wv) begin
      chk("R7 wake_exc", wake_exc, m_exc);
      chk("R8 wake_cause", wake_cause, m_cause);
    end
    chk("R9 rf_div", rf_div, m_rf);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    model();
    cmp();
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_we = 0; cfg_wdata = '0; periph_irq = '0; ext_int = '0;
    nmi = 0; core_rst_req = 0; bus_req = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset mode", mode, 0);
    chk("R1 reset core_clk_en", core_clk_en, 1);
    chk("R1 reset wb_clk_en", wb_clk_en, 1);
    chk("R1 reset bus_ack", bus_ack, 0);
    chk("R1 reset wake_valid", wake_valid, 0);
    chk("R1 reset rf_div", rf_div, 0);
    @(negedge clk);

    cfg_we = 1; cfg_wdata = 16'h0302; bus_req = 1; cyc();
    chk("R2 halt wins over doze", mode, 1);
    chk("R4 no grant in halt", bus_ack, 0);
    idle(); ext_int = 8'h01; int_mask = 9'h000; cyc(); cyc();
    chk("R5 R10 masked interrupt keeps halt", mode, 1);
    int_mask = 9'h001; cyc();
    chk("R5 R7 R10 halt exit on enabled line", wake_valid, 1);
    chk("R7 halt exit takes exception", wake_exc, 1);
    chk("R8 interrupt cause", wake_cause, 3);
    idle(); cyc();
    chk("R7 wake pulse one cycle", wake_valid, 0);

    cfg_we = 1; cfg_wdata = 16'h0200; wb_empty = 0; cyc();
    chk("R3 doze entered", mode, 2);
    chk("R3 write buffer drains", wb_clk_en, 1);
    idle(); wb_empty = 1; bus_req = 1; cyc();
    chk("R3 write buffer stopped when empty", wb_clk_en, 0);
    chk("R4 grant in doze", bus_ack, 1);
    idle(); cfg_we = 1; cfg_wdata = 16'h0103; cyc();
    chk("R9 write in doze keeps mode", mode, 2);
    chk("R9 divider loads in doze", rf_div, 3);
    idle(); int_mask = 9'h0FF; periph_irq = 4'h4; cyc();
    chk("R6 R10 doze exit on disabled peripheral", mode, 0);
    chk("R7 disabled wake resumes", wake_exc, 0);

    idle(); cfg_we = 1; cfg_wdata = 16'h0200; cyc();
    idle(); core_rst_req = 1; nmi = 1; ext_int = 8'hFF; cyc();
    chk("R8 reset outranks NMI", wake_cause, 1);
    idle(); cfg_we = 1; cfg_wdata = 16'h0100; cyc();
    idle(); nmi = 1; ext_int = 8'h80; int_mask = 9'h080; cyc();
    chk("R8 NMI outranks interrupt", wake_cause, 2);
    idle(); cyc();

    for (int i = 0; i < 4000; i++) begin
      cfg_we       = ($urandom_range(0, 5) == 0);
      cfg_wdata    = 16'($urandom);
      ext_int      = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00;
      periph_irq   = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'h0;
      nmi          = ($urandom_range(0, 39) == 0);
      core_rst_req = ($urandom_range(0, 59) == 0);
      int_mask     = 9'($urandom);
      wb_empty     = $urandom_range(0, 1) == 1;
      bus_req      = $urandom_range(0, 1) == 1;
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule